// File: doc/BRIEF.md
# Transmit Echo Real-Time Error Checker

This block sits beside a serial transmitter whose line is looped back by the far station. It watches the outgoing serial stream and the returning stream. Every bit-time strobe, it takes a sample of the transmit line and sends it through a two-stage delay line. It then compares the tap the configuration picks, one or two bit times late, against the bit now present on the receive line. The check runs bit by bit while the character is still on the wire, so a faulty channel shows up without waiting for the whole message.

A character is marked by a frame-start strobe that arrives with the bit-time strobe on which the start bit goes out. The block tracks the bit position of every sample it delays. A compare counts only while the delayed sample belongs to a character, from its start bit through its last stop bit. A mismatch gives a one-cycle error pulse and latches the position of the failing bit. It also sets a sticky flag, which software clears by writing one.

Top module: `echo_check`

## Requirements
- R1: After reset, err_pulse is 0, err_idx is 0 and err_sticky is 0.
- R2: With cfg_two_bit = 0, rx_line sampled on a bit_tick is compared with the tx_line value sampled on the previous bit_tick.
- R3: With cfg_two_bit = 1, rx_line sampled on a bit_tick is compared with the tx_line value sampled two bit_ticks earlier.
- R4: A compare counts only when its delayed sample lies inside a character. A character starts at the bit_tick that carries frame_start. It is 1 + cfg_nbits + cfg_parity + (cfg_stop2 ? 2 : 1) ticks long, with cfg_nbits from 5 to DMAX. Mismatches on other ticks are ignored.
- R5: err_idx gives the position of the failing bit inside its character: 0 for the start bit, 1..cfg_nbits for the data bits, then the parity bit if enabled, then the stop bits. It holds its value until the next mismatch.
- R6: A mismatch at a bit_tick edge drives err_pulse high for exactly the one following clock cycle.
- R7: err_sticky is set by any mismatch and stays set until a cycle with err_clr = 1. A mismatch in the same cycle as err_clr leaves it set.
- R8: With chk_en = 0, no mismatch raises err_pulse or changes err_sticky.
- R9: rx_line and tx_line are sampled only on bit_tick. Changes between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time, at the bit sample point |
| frame_start | input | 1 | With bit_tick, marks that the start bit is on tx_line |
| tx_line | input | 1 | Outgoing serial line |
| rx_line | input | 1 | Echoed serial line from the far end |
| chk_en | input | 1 | Enables error reporting |
| cfg_two_bit | input | 1 | 0: one bit time of delay, 1: two |
| cfg_nbits | input | $clog2(DMAX+1) | Data bits per character (5..DMAX) |
| cfg_parity | input | 1 | Character carries a parity bit |
| cfg_stop2 | input | 1 | Character carries two stop bits |
| err_clr | input | 1 | Write-one-to-clear of err_sticky |
| err_pulse | output | 1 | One-cycle mismatch indication |
| err_idx | output | $clog2(DMAX+4) | Position of the last failing bit |
| err_sticky | output | 1 | Latched error flag |

## Verification
The bench injects a single flipped bit at each kind of position: start, data, parity and last stop. A design with an off-by-one in its position pipeline would report the wrong err_idx, or it would flag the stop bit as falling outside the window. An echo aligned to the wrong delay must give a burst of mismatches only where the stream's bits differ, and none on the idle ticks on either side of the character. A design that compared outside the window would flag those idle ticks. The bench also glitches rx_line between strobes, which would trip a design that samples the line on every cycle. It sends characters with checking disabled, which would catch a checker that still sets the flag. It clears the flag on the same cycle as a new error, so a design in which the clear wins would drop that error.

// File: rtl/echo_check.sv
module echo_check #(
  parameter int DMAX = 8,
  localparam int IDX_W = $clog2(DMAX + 4),
  localparam int NB_W = $clog2(DMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_start,
  input  logic             tx_line,
  input  logic             rx_line,
  input  logic             chk_en,
  input  logic             cfg_two_bit,
  input  logic [NB_W-1:0]  cfg_nbits,
  input  logic             cfg_parity,
  input  logic             cfg_stop2,
  input  logic             err_clr,
  output logic             err_pulse,
  output logic [IDX_W-1:0] err_idx,
  output logic             err_sticky
);

  logic [IDX_W-1:0] nb_eff, flen, cnt, pos_now, pos1, pos2, cmp_pos;
  logic act, v_now, v1, v2, d1, d2, cmp_v, cmp_b, miss;

  assign nb_eff  = (cfg_nbits > NB_W'(DMAX)) ? IDX_W'(DMAX) : IDX_W'(cfg_nbits);
  assign flen    = IDX_W'(1) + nb_eff + IDX_W'(cfg_parity) + (cfg_stop2 ? IDX_W'(2) : IDX_W'(1));
  assign v_now   = frame_start | (act & (cnt < flen));
  assign pos_now = frame_start ? '0 : cnt;

  assign cmp_v   = cfg_two_bit ? v2   : v1;
  assign cmp_b   = cfg_two_bit ? d2   : d1;
  assign cmp_pos = cfg_two_bit ? pos2 : pos1;
  assign miss    = bit_tick & chk_en & cmp_v & (rx_line != cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= 1'b1;
      d2 <= 1'b1;
      v1 <= 1'b0;
      v2 <= 1'b0;
      pos1 <= '0;
      pos2 <= '0;
      act <= 1'b0;
      cnt <= '0;
    end else if (bit_tick) begin
      d1 <= tx_line;
      d2 <= d1;
      v1 <= v_now;
      v2 <= v1;
      pos1 <= pos_now;
      pos2 <= pos1;
      act <= v_now;
      if (v_now) cnt <= pos_now + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_idx    <= '0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse  <= miss;
      if (miss) err_idx <= cmp_pos;
      err_sticky <= miss | (err_sticky & ~err_clr);
    end
  end

  p_pulse_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(bit_tick) && $past(chk_en)));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !err_sticky) |=> !err_sticky);
  p_rise_needs_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> err_pulse);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_pulse || !err_sticky));
  p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);
  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_idx));
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_idx < IDX_W'(DMAX + 4)));

endmodule

// File: tb/tb_echo_check.sv
module tb_echo_check;
  localparam int CLK_P = 10;
  localparam int DMAX = 8;
  localparam int IDX_W = $clog2(DMAX + 4);
  localparam int NB_W = $clog2(DMAX + 1);

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, frame_start = 0, tx_line = 1, rx_line = 1;
  logic chk_en = 1, cfg_two_bit = 0, cfg_parity = 0, cfg_stop2 = 0, err_clr = 0;
  logic [NB_W-1:0] cfg_nbits = NB_W'(8);
  logic err_pulse, err_sticky;
  logic [IDX_W-1:0] err_idx;

  int n_chk = 0, n_err = 0;
  bit exp_sticky = 0;
  int exp_idx = 0;

  always #(CLK_P/2) clk = ~clk;

  echo_check #(.DMAX(DMAX)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .tx_line(tx_line), .rx_line(rx_line), .chk_en(chk_en), .cfg_two_bit(cfg_two_bit),
    .cfg_nbits(cfg_nbits), .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2),
    .err_clr(err_clr), .err_pulse(err_pulse), .err_idx(err_idx), .err_sticky(err_sticky));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flen(input int nb, input bit par, input bit st2);
    return 1 + nb + int'(par) + (st2 ? 2 : 1);
  endfunction

  // one bit time: strobe, then check, then gap with rx glitches (R9)
  task automatic do_tick(input bit tx, input bit rx, input bit fs, input bit clr,
                         input bit exp_p, input int idx, input string req);
    @(negedge clk);
    bit_tick = 1; tx_line = tx; rx_line = rx; frame_start = fs; err_clr = clr;
    @(negedge clk);
    bit_tick = 0; frame_start = 0; err_clr = 0;
    tx_line = 1'($urandom); rx_line = 1'($urandom);
    if (exp_p) begin exp_sticky = 1; exp_idx = idx; end
    else if (clr) exp_sticky = 0;
    chk(err_pulse == exp_p, {req, " pulse"}, int'(err_pulse), int'(exp_p));
    chk(int'(err_idx) == exp_idx, "R5 idx", int'(err_idx), exp_idx);
    chk(err_sticky == exp_sticky, "R7 sticky", int'(err_sticky), int'(exp_sticky));
    @(negedge clk);
    chk(err_pulse == 1'b0, "R6 single cycle", int'(err_pulse), 0);
  endtask

  // rd: actual echo delay; ep: flipped echo position or -1; clr_k: tick with err_clr
  task automatic run_frame(input int nb, input bit par, input bit st2, input bit two,
                           input int rd, input logic [7:0] data, input int ep,
                           input bit en, input int clr_k, input string req);
    logic [15:0] bits;
    int l = flen(nb, par, st2);
    int dl = two ? 2 : 1;
    cfg_nbits = NB_W'(nb); cfg_parity = par; cfg_stop2 = st2;
    cfg_two_bit = two; chk_en = en;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[1+i] = data[i];
    if (par) bits[1+nb] = ^(data & 8'((1 << nb) - 1));
    for (int k = 0; k < l + 3; k++) begin
      int j = k - rd;
      int w = k - dl;
      bit txv = (k < l) ? bits[k] : 1'b1;
      bit rxv = (j >= 0 && j < l) ? (bits[j] ^ (j == ep)) : 1'b1;
      bit ref_b = (w >= 0 && w < l) ? bits[w] : 1'b1;
      bit ep_exp = en && (w >= 0 && w < l) && (rxv != ref_b);
      do_tick(txv, rxv, k == 0, k == clr_k, ep_exp, w, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(err_pulse == 0, "R1 pulse", int'(err_pulse), 0);
    chk(err_idx == 0, "R1 idx", int'(err_idx), 0);
    chk(err_sticky == 0, "R1 sticky", int'(err_sticky), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed corners
    run_frame(8, 0, 0, 0, 1, 8'hA5, -1, 1, -1, "R2 clean echo");
    run_frame(8, 0, 0, 0, 1, 8'hA5, 0, 1, -1, "R5 start bit");
    run_frame(7, 1, 0, 1, 2, 8'h3C, 8, 1, -1, "R5 parity bit");
    run_frame(5, 1, 1, 1, 2, 8'h15, 8, 1, -1, "R4 last stop");
    run_frame(6, 0, 0, 1, 2, 8'h2B, 3, 1, -1, "R3 data bit");
    run_frame(8, 1, 1, 1, 1, 8'h96, -1, 1, -1, "R3 wrong echo delay");
    run_frame(8, 0, 0, 0, 2, 8'h0F, -1, 1, -1, "R2 wrong echo delay");
    run_frame(8, 0, 1, 0, 0, 8'h55, -1, 1, -1, "R4 zero-delay echo");
    run_frame(8, 0, 0, 0, 1, 8'hFF, 4, 0, -1, "R8 disabled");
    run_frame(8, 0, 0, 0, 1, 8'h00, -1, 1, 2, "R7 clear");
    run_frame(8, 0, 0, 0, 1, 8'h81, 2, 1, 3, "R7 clear with error");
    run_frame(8, 0, 0, 0, 1, 8'h81, -1, 1, 1, "R7 clear after error");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int nb = 5 + int'($urandom_range(0, DMAX - 5));
      bit par = 1'($urandom);
      bit st2 = 1'($urandom);
      bit two = 1'($urandom);
      int l = flen(nb, par, st2);
      int ep = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, l - 1));
      int rd = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 2)) : (two ? 2 : 1);
      bit en = ($urandom_range(0, 5) != 0);
      int ck = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, l + 2)) : -1;
      run_frame(nb, par, st2, two, rd, 8'($urandom), ep, en, ck,
                two ? "R3 random" : "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule